// File: doc/BRIEF.md
# Paper Tape Feed Stepper with Sprocket Watchdog

This block turns the friction roller of a paper tape reader by driving a two-coil stepper motor. While a search for the next sprocket hole is under way, every timer tick advances the motor by one phase. The phase pattern is written into the two low bits of an 8-bit reader control register image, and the upper six bits of that image are left untouched.

A watchdog counts the steps taken since the last sprocket interrupt. A sprocket pulse restarts that count. If the count reaches a fixed limit (20 by default), the search is abandoned. The searching flag drops, the pending-sprocket flag is cleared, a one-cycle timeout pulse is raised, and two control bits are forced: bit 2 is set and bit 3 is cleared. A start command arms a new search.

Top module: `tape_feed_stepper`

## Requirements
- R1: While reset is low, and in the first cycle after it, `ctrl_port` equals `CTRL_INIT` (default 0x00). `searching`, `timeout_pulse` and `sprocket_pend` are all 0.
- R2: Each tick taken while `searching` is 1 writes a new phase into `ctrl_port[1:0]`, visible one cycle later. Starting from reset, the phases follow the repeating order 00, 01, 11, 10. The position in this order is kept across searches and timeouts.
- R3: Every change of `ctrl_port[1:0]` flips exactly one bit.
- R4: Steps never change `ctrl_port[7:2]`.
- R5: When `searching` is 0 or `step_tick` is 0, `ctrl_port[1:0]` keeps its value.
- R6: `search_start` sets `searching` in the next cycle and restarts the step count at zero.
- R7: The LIMIT-th stepped tick (20th by default) after the count was last restarted is a timeout, unless `sprocket_pulse` or `search_start` is high in the same cycle. One cycle after the timeout tick, all of the following hold:
  - `searching` is 0.
  - `ctrl_port[2]` is 1 and `ctrl_port[3]` is 0.
  - The other bits of `ctrl_port` hold their values.
  - The phase of that tick has been written.
- R8: `sprocket_pulse` restarts the step count at zero, so a full LIMIT further stepped ticks are then needed before a timeout.
- R9: `sprocket_pend` becomes 1 the cycle after `sprocket_pulse`. A timeout clears it.
- R10: `timeout_pulse` is 1 for exactly one cycle per timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_tick | input | 1 | Step timer tick, one cycle wide |
| sprocket_pulse | input | 1 | Sprocket hole interrupt, one cycle wide |
| search_start | input | 1 | Starts a sprocket search |
| ctrl_port | output | 8 | Reader control register image; bits 1:0 hold the motor phase |
| searching | output | 1 | A sprocket search is in progress |
| timeout_pulse | output | 1 | One-cycle pulse for each abandoned search |
| sprocket_pend | output | 1 | A sprocket interrupt is pending |

## Verification
The stepper is driven with several input patterns:
- Ticks arriving while no search is active separate gated stepping from free-running stepping.
- Dense ticks and sparse ticks show that the phase advances per tick and not per clock.
- A sprocket pulse landing after a number of steps, with nineteen ticks following it, separates a restarted count from a count that carries on.
- A sprocket pulse in the same cycle as a tick checks that the restart has priority over the increment.
- A second search, begun after the first has already forced bit 2, shows whether stepping disturbs the upper bits.

// File: rtl/tfs_pkg.sv
// Shared definitions for the tape feed stepper.
// Assumes a two-bit motor phase at the bottom of the control byte.
package tfs_pkg;
    localparam int unsigned PHASE_W = 2;
    localparam int unsigned PORT_W  = 8;

    // Reflected binary code of a phase index.
    function automatic logic [PHASE_W-1:0] idx_to_phase(input logic [PHASE_W-1:0] idx);
        return idx ^ (idx >> 1);
    endfunction
endpackage

// File: rtl/tfs_phase_gen.sv
// Phase sequencer: keeps a free-running phase index and presents its
// reflected code. The index advances once for each accepted step.
// Assumes: the caller writes `phase` into the port in the same cycle it raises `adv`.
module tfs_phase_gen
    import tfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    output logic [PHASE_W-1:0] phase
);
    logic [PHASE_W-1:0] idx_q;

    // Advance the index on each accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx_q <= '0;
        else if (adv) idx_q <= idx_q + 1'b1;
    end

    // Phase pattern derived from the current index.
    always_comb phase = idx_to_phase(idx_q);
endmodule

// File: rtl/tfs_miss_watch.sv
// Missed-sprocket watchdog: counts steps since the last restart and
// flags expiry on the LIMIT-th one.
// Assumes: LIMIT >= 2; `restart` wins over a step in the same cycle.
module tfs_miss_watch #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CW   = $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Expiry when the step that would reach LIMIT arrives.
    always_comb expire = step && !restart && (cnt_q == LAST);

    // Step counter with restart and wrap to zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart || expire) cnt_q <= '0;
        else if (step)              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tape_feed_stepper.sv
// Tape feed stepper top: steps the reader motor while searching and
// abandons the search when no sprocket arrives within LIMIT steps.
// Assumes: one-cycle input pulses; all outputs are registered.
module tape_feed_stepper
    import tfs_pkg::*;
#(
    parameter int unsigned        LIMIT     = 20,
    parameter logic [PORT_W-1:0]  CTRL_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    input  logic              sprocket_pulse,
    input  logic              search_start,
    output logic [PORT_W-1:0] ctrl_port,
    output logic              searching,
    output logic              timeout_pulse,
    output logic              sprocket_pend
);
    localparam int unsigned SET_BIT = 2;
    localparam int unsigned CLR_BIT = 3;

    logic               step_en;
    logic               restart;
    logic               expire;
    logic [PHASE_W-1:0] phase;
    logic [PORT_W-1:0]  port_nxt;

    // Accepted steps and watchdog restarts.
    always_comb begin
        step_en = searching && step_tick;
        restart = search_start || sprocket_pulse;
    end

    tfs_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (step_en),
        .phase (phase)
    );

    tfs_miss_watch #(.LIMIT(LIMIT)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_en),
        .restart (restart),
        .expire  (expire)
    );

    // Next control image: the phase goes into the low bits, expiry forces two bits.
    always_comb begin
        port_nxt = ctrl_port;
        if (step_en) port_nxt[PHASE_W-1:0] = phase;
        if (expire) begin
            port_nxt[SET_BIT] = 1'b1;
            port_nxt[CLR_BIT] = 1'b0;
        end
    end

    // Control image register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_port <= CTRL_INIT;
        else        ctrl_port <= port_nxt;
    end

    // Search flag: start arms it, expiry drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)            searching <= 1'b0;
        else if (search_start) searching <= 1'b1;
        else if (expire)       searching <= 1'b0;
    end

    // Pending sprocket flag and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sprocket_pend <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            if (sprocket_pulse) sprocket_pend <= 1'b1;
            else if (expire)    sprocket_pend <= 1'b0;
            timeout_pulse <= expire;
        end
    end
endmodule

// File: rtl/tape_feed_stepper_chk.sv
// Property checker for the tape feed stepper, attached by bind.
// Assumes the default bit layout: phase in bits 1:0, forced bits 2 and 3.
module tape_feed_stepper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_tick,
    input logic [7:0] ctrl_port,
    input logic       searching,
    input logic       timeout_pulse,
    input logic       sprocket_pend
);
    // R3
    phase_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_port[1:0] != $past(ctrl_port[1:0])) |->
            ($countones(ctrl_port[1:0] ^ $past(ctrl_port[1:0])) == 1));

    // R4
    upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !timeout_pulse |-> (ctrl_port[7:2] == $past(ctrl_port[7:2])));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(searching) || !$past(step_tick)) |-> $stable(ctrl_port[1:0]));

    // R7
    abandon_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (!searching && ctrl_port[2] && !ctrl_port[3]));

    // R9
    pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> !sprocket_pend);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);
endmodule

bind tape_feed_stepper tape_feed_stepper_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_tick     (step_tick),
    .ctrl_port     (ctrl_port),
    .searching     (searching),
    .timeout_pulse (timeout_pulse),
    .sprocket_pend (sprocket_pend)
);

// File: tb/tape_feed_stepper_tb_top.sv
`timescale 1ns/1ps
module tape_feed_stepper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_tick = 1'b0;
    logic       sprocket_pulse = 1'b0;
    logic       search_start = 1'b0;
    logic [7:0] ctrl_port;
    logic       searching;
    logic       timeout_pulse;
    logic       sprocket_pend;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    int m_idx = 0, m_cnt = 0, m_port = 0;
    bit m_srch = 0, m_pend = 0, m_to = 0;
    int gray_tab[4] = '{0, 1, 3, 2};

    always #2.5 clk = ~clk;

    tape_feed_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
        .sprocket_pulse(sprocket_pulse), .search_start(search_start),
        .ctrl_port(ctrl_port), .searching(searching),
        .timeout_pulse(timeout_pulse), .sprocket_pend(sprocket_pend)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " ctrl_port"}, int'(ctrl_port), m_port);
        chk({tag, " searching"}, int'(searching), int'(m_srch));
        chk({tag, " timeout_pulse"}, int'(timeout_pulse), int'(m_to));
        chk({tag, " sprocket_pend"}, int'(sprocket_pend), int'(m_pend));
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic cyc(bit t, bit p, bit s, string tag);
        int prev = int'(ctrl_port[1:0]);
        bit step;
        bit to;
        step_tick = t; sprocket_pulse = p; search_start = s;
        step = m_srch && t;
        to = step && !p && !s && (m_cnt + 1 == 20);
        if (step) begin
            m_port = (m_port & 'hFC) | gray_tab[m_idx % 4];
            m_idx++;
        end
        if (to) begin
            m_port = (m_port | 'h04) & ~'h08;
            m_srch = 0;
            m_pend = 0;
        end
        if (s) m_srch = 1;
        if (p) m_pend = 1;
        if (s || p || to) m_cnt = 0;
        else if (step) m_cnt++;
        m_to = to;
        @(posedge clk); #1;
        compare_all(tag);
        if (int'(ctrl_port[1:0]) != prev)
            chk("R3 one-bit phase change", $countones(ctrl_port[1:0] ^ prev[1:0]), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1 reset");
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1 after reset");

        // No search active: ticks must not step.
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R5 idle ticks");

        cyc(0, 0, 1, "R6 start");
        chk("R6 searching set", int'(searching), 1);

        // Dense and sparse ticks.
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R2 dense");
        for (int i = 0; i < 6; i++) cyc(i % 2, 0, 0, "R2 sparse");

        // Sprocket restarts the count.
        cyc(0, 1, 0, "R8 sprocket");
        chk("R9 pend set", int'(sprocket_pend), 1);
        for (int i = 0; i < 19; i++) cyc(1, 0, 0, "R8 no early timeout");
        cyc(1, 0, 0, "R7 timeout tick");
        chk("R7 pulse", int'(timeout_pulse), 1);
        chk("R7 bits 3:2", int'(ctrl_port[3:2]), 1);
        chk("R9 pend cleared", int'(sprocket_pend), 0);
        cyc(0, 0, 0, "R10 pulse ends");
        chk("R10 single cycle", int'(timeout_pulse), 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R5 after timeout");

        // Second search: upper bits stay, sprocket with tick in the same cycle.
        cyc(0, 0, 1, "R6 restart");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R4 stepping");
        chk("R4 upper bits", int'(ctrl_port[7:2]), 1);
        cyc(1, 1, 0, "R8 sprocket with tick");
        for (int i = 0; i < 19; i++) cyc(1, 0, 0, "R8 recount");
        cyc(1, 0, 0, "R7 second timeout");
        chk("R7 second pulse", int'(timeout_pulse), 1);
        cyc(0, 0, 0, "R10 second end");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule